// File: doc/BRIEF.md
# Selective Checkpoint Recovery Queue

This block keeps recovery points for a small out-of-order core without giving every instruction an entry. A checkpoint is opened only where recovery is likely to be needed: at a branch the predictor marks as low-confidence, and at the first load or store of a run of memory operations. Each checkpoint holds a copy of the rename map as it stood just before its opening instruction. It also keeps two counters, one for the instructions issued inside its region and one for those completed there. A whole region retires in one step once every instruction in it has completed.

A mispredicted branch or a faulting memory group rolls the live rename map back to one checkpoint in a single cycle and squashes everything younger. A fault in a memory group also puts the queue into a limp-home mode. In that mode every memory operation gets its own checkpoint, so that a repeated fault can be reported against one exact operation. Limp-home mode ends when that fault is reported, or after `LIMP_QUIET` memory operations complete cleanly.

Dispatch is a valid/ready stream. An instruction is taken on a cycle where `disp_valid` and `disp_ready` are both high. `disp_tag` names the checkpoint the instruction belongs to and is valid on that cycle. Retirement is a valid/ready stream too: once `retire_valid` rises, it and `retire_tag` hold until `retire_ready` takes the entry. If a mispredict and a group fault arrive in the same cycle, the rollback goes to the older of the two checkpoints, and limp-home mode is entered only when the fault's checkpoint is the one chosen. `DEPTH` must be a power of two.

Top module: `spec_ckpt_queue`

## Requirements
- R1: A branch with `disp_lowconf`=1 opens a new checkpoint in the slot at the tail. A high-confidence branch or an ALU instruction joins the youngest checkpoint. The class codes are ALU=0, branch=1, memory=2. A tag is {generation bit, slot index}, and every new opening of a slot inverts that slot's generation bit.
- R2: A mispredict on a live tag restores that checkpoint's map snapshot in the next cycle. All younger checkpoints are discarded, and the restored checkpoint becomes the youngest one with both counters at zero. `disp_ready` is low during the rollback cycle.
- R3: A memory operation opens a checkpoint only if the previously accepted instruction was not a memory operation. Later consecutive memory operations share that checkpoint.
- R4: A faulting completion on a memory checkpoint outside limp-home mode rolls back to that checkpoint the same way as R2. It sets `limp_mode` and does not pulse `fault_report_valid`.
- R5: In limp-home mode every memory operation opens its own checkpoint. A faulting completion on one of them rolls back to it. In the next cycle it pulses `fault_report_valid` for one cycle with that tag and clears `limp_mode`.
- R6: `LIMP_QUIET` clean completions of memory checkpoints during limp-home mode clear `limp_mode`, and grouping of memory operations resumes after that.
- R7: Checkpoints retire in allocation order. The oldest one is offered only when it is not the youngest, its completed count equals its issued count, and no rollback happens in that cycle. A memory operation counts as complete once its address translation is signalled on the completion port.
- R8: When all `DEPTH` slots are in use, an instruction that needs a new checkpoint sees `disp_ready`=0. An instruction that joins the youngest checkpoint is still accepted.
- R9: A completion or mispredict whose generation bit does not match its slot, or whose slot is free, has no effect.
- R10: After reset, one checkpoint with tag 0 exists, the map sends architectural register i to physical register i, and `retire_valid`, `limp_mode` and `fault_report_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | Dispatch accepted this cycle |
| disp_class | input | 2 | 0 ALU, 1 branch, 2 memory |
| disp_lowconf | input | 1 | Branch predicted with low confidence |
| disp_dst_en | input | 1 | Instruction writes a destination |
| disp_dst_arch | input | $clog2(NUM_ARCH) | Destination architectural register |
| disp_dst_phys | input | PHYS_W | Physical register newly mapped |
| disp_tag | output | $clog2(DEPTH)+1 | Checkpoint of the offered instruction |
| cmp_valid | input | 1 | Completion (translation done for memory) |
| cmp_tag | input | $clog2(DEPTH)+1 | Checkpoint of the completed instruction |
| cmp_fault | input | 1 | Completion reports a fault |
| mis_valid | input | 1 | Branch mispredict |
| mis_tag | input | $clog2(DEPTH)+1 | Checkpoint of the mispredicted branch |
| retire_valid | output | 1 | Oldest checkpoint may retire |
| retire_ready | input | 1 | Retire stage takes the checkpoint |
| retire_tag | output | $clog2(DEPTH)+1 | Tag of the oldest checkpoint |
| limp_mode | output | 1 | One checkpoint per memory operation |
| fault_report_valid | output | 1 | Precise fault pulse |
| fault_report_tag | output | $clog2(DEPTH)+1 | Checkpoint of the reported fault |
| map_flat | output | NUM_ARCH*PHYS_W | Live rename map, register i at bits [i*PHYS_W +: PHYS_W] |

## Verification
Allocation is driven with a mixed stream of ALU instructions, branches of both confidence levels, and runs of memory operations. This separates joining the youngest checkpoint from opening a new one, and it shows whether a memory run ends at the first non-memory instruction. The queue is filled so that a branch that needs a checkpoint stalls while a memory operation joining the open group still goes through. Rollbacks are applied both from a mispredict and from a group fault, with map contents that differ from the snapshots, so a restore from the wrong slot shows in the map. After the rollback, a completion carrying the old generation of a reused slot checks that such a completion cannot make a region retire. Limp-home mode is ended once by a precise fault and once by clean completions, to show the two ways out.

// File: rtl/scq_pkg.sv
package scq_pkg;
  typedef enum logic [1:0] {
    CLS_ALU = 2'd0,
    CLS_BR  = 2'd1,
    CLS_MEM = 2'd2
  } iclass_e;
endpackage

// File: rtl/scq_rename_map.sv
module scq_rename_map #(
  parameter int NUM_ARCH = 4,
  parameter int PHYS_W   = 4,
  localparam int AW      = $clog2(NUM_ARCH),
  localparam int MAP_W   = NUM_ARCH * PHYS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_arch,
  input  logic [PHYS_W-1:0] wr_phys,
  input  logic             restore_en,
  input  logic [MAP_W-1:0] restore_map,
  output logic [MAP_W-1:0] cur_map
);
  function automatic logic [MAP_W-1:0] ident_map();
    logic [MAP_W-1:0] m;
    for (int k = 0; k < NUM_ARCH; k++) m[k*PHYS_W +: PHYS_W] = PHYS_W'(k);
    return m;
  endfunction

  logic [MAP_W-1:0] map_q;
  assign cur_map = map_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_q <= ident_map();
    end else if (restore_en) begin
      map_q <= restore_map;
    end else if (wr_en) begin
      map_q[wr_arch*PHYS_W +: PHYS_W] <= wr_phys;
    end
  end

  // R2: the snapshot appears one cycle after a restore
  assert_map_restore_R2: assert property (@(posedge clk) disable iff (!rst_n)
    restore_en |=> (cur_map == $past(restore_map)));
endmodule

// File: rtl/scq_slot_array.sv
module scq_slot_array #(
  parameter int DEPTH    = 4,
  parameter int NUM_ARCH = 4,
  parameter int PHYS_W   = 4,
  parameter int CNT_W    = 4,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int MAP_W   = NUM_ARCH * PHYS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic [IDX_W-1:0] alloc_idx,
  input  logic             alloc_mem,
  input  logic [MAP_W-1:0] alloc_snap,
  input  logic             issue_en,
  input  logic [IDX_W-1:0] issue_idx,
  input  logic             cmp_en,
  input  logic [IDX_W-1:0] cmp_idx,
  input  logic             rb_en,
  input  logic [IDX_W-1:0] rb_idx,
  input  logic [DEPTH-1:0] squash_vec,
  input  logic             retire_en,
  input  logic [IDX_W-1:0] retire_idx,
  output logic [DEPTH-1:0] valid_vec,
  output logic [DEPTH-1:0] gen_vec,
  output logic [DEPTH-1:0] mem_vec,
  output logic [DEPTH-1:0] bal_vec,
  output logic [MAP_W-1:0] rb_snap
);
  function automatic logic [MAP_W-1:0] ident_map();
    logic [MAP_W-1:0] m;
    for (int k = 0; k < NUM_ARCH; k++) m[k*PHYS_W +: PHYS_W] = PHYS_W'(k);
    return m;
  endfunction

  logic [DEPTH*MAP_W-1:0] snap_flat;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    localparam logic [IDX_W-1:0] MY = IDX_W'(i);
    logic             valid_q, gen_q, mem_q;
    logic [CNT_W-1:0] iss_q, cpl_q;
    logic [MAP_W-1:0] snap_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q <= (i == 0);
        gen_q   <= 1'b0;
        mem_q   <= 1'b0;
        iss_q   <= '0;
        cpl_q   <= '0;
        snap_q  <= ident_map();
      end else if (rb_en && squash_vec[i]) begin
        valid_q <= 1'b0;
      end else if (rb_en && rb_idx == MY) begin
        iss_q <= '0;
        cpl_q <= '0;
      end else begin
        if (alloc_en && alloc_idx == MY) begin
          valid_q <= 1'b1;
          gen_q   <= ~gen_q;
          mem_q   <= alloc_mem;
          snap_q  <= alloc_snap;
          iss_q   <= issue_en ? CNT_W'(1) : '0;
          cpl_q   <= '0;
        end else begin
          if (issue_en && issue_idx == MY) iss_q <= iss_q + 1'b1;
          if (cmp_en && cmp_idx == MY)     cpl_q <= cpl_q + 1'b1;
        end
        if (retire_en && retire_idx == MY) valid_q <= 1'b0;
      end
    end

    assign valid_vec[i] = valid_q;
    assign gen_vec[i]   = gen_q;
    assign mem_vec[i]   = mem_q;
    assign bal_vec[i]   = (iss_q == cpl_q);
    assign snap_flat[i*MAP_W +: MAP_W] = snap_q;

    // R9: a live region never counts more completions than issues
    assert_cpl_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |-> (cpl_q <= iss_q));
  end

  assign rb_snap = snap_flat[rb_idx*MAP_W +: MAP_W];
endmodule

// File: rtl/scq_limp_ctrl.sv
module scq_limp_ctrl #(
  parameter int LIMP_QUIET = 2,
  parameter int TAG_W      = 3,
  localparam int QW        = $clog2(LIMP_QUIET + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enter,
  input  logic             report,
  input  logic [TAG_W-1:0] report_tag,
  input  logic             clean_cmp,
  output logic             limp,
  output logic             rep_valid,
  output logic [TAG_W-1:0] rep_tag
);
  logic [QW-1:0] quiet_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      limp      <= 1'b0;
      quiet_q   <= '0;
      rep_valid <= 1'b0;
      rep_tag   <= '0;
    end else begin
      rep_valid <= 1'b0;
      if (enter) begin
        limp    <= 1'b1;
        quiet_q <= '0;
      end else if (report) begin
        limp      <= 1'b0;
        rep_valid <= 1'b1;
        rep_tag   <= report_tag;
      end else if (limp && clean_cmp) begin
        if (quiet_q + 1'b1 == QW'(LIMP_QUIET)) begin
          limp    <= 1'b0;
          quiet_q <= '0;
        end else begin
          quiet_q <= quiet_q + 1'b1;
        end
      end
    end
  end

  // R5: a precise report always leaves limp-home mode
  assert_report_exits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid |-> !limp);
  // R6: the quiet count stays below its limit
  assert_quiet_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    quiet_q < QW'(LIMP_QUIET));
endmodule

// File: rtl/spec_ckpt_queue.sv
module spec_ckpt_queue
  import scq_pkg::*;
#(
  parameter int DEPTH      = 4,
  parameter int NUM_ARCH   = 4,
  parameter int PHYS_W     = 4,
  parameter int CNT_W      = 4,
  parameter int LIMP_QUIET = 2,
  localparam int IDX_W     = $clog2(DEPTH),
  localparam int TAG_W     = IDX_W + 1,
  localparam int AW        = $clog2(NUM_ARCH),
  localparam int MAP_W     = NUM_ARCH * PHYS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_valid,
  output logic              disp_ready,
  input  logic [1:0]        disp_class,
  input  logic              disp_lowconf,
  input  logic              disp_dst_en,
  input  logic [AW-1:0]     disp_dst_arch,
  input  logic [PHYS_W-1:0] disp_dst_phys,
  output logic [TAG_W-1:0]  disp_tag,
  input  logic              cmp_valid,
  input  logic [TAG_W-1:0]  cmp_tag,
  input  logic              cmp_fault,
  input  logic              mis_valid,
  input  logic [TAG_W-1:0]  mis_tag,
  output logic              retire_valid,
  input  logic              retire_ready,
  output logic [TAG_W-1:0]  retire_tag,
  output logic              limp_mode,
  output logic              fault_report_valid,
  output logic [TAG_W-1:0]  fault_report_tag,
  output logic [MAP_W-1:0]  map_flat
);
  logic [IDX_W-1:0] head_q, tail_q, youngest;
  logic [IDX_W:0]   count_q;
  logic             mem_open_q;
  logic [DEPTH-1:0] valid_vec, gen_vec, mem_vec, bal_vec, squash_vec;
  logic [MAP_W-1:0] cur_map, rb_snap;
  iclass_e          cls;

  logic [IDX_W-1:0] cmp_idx, mis_idx, rb_idx, rb_age, issue_idx;
  logic             cmp_live, mis_live, fault_hit, rb_sel_fault, do_rb;
  logic             need_ckpt, full, disp_fire, alloc, retire_fire, clean_cmp;

  assign cls      = iclass_e'(disp_class);
  assign youngest = tail_q - 1'b1;
  assign full     = (count_q == (IDX_W+1)'(DEPTH));

  // tag decode and liveness
  assign cmp_idx  = cmp_tag[IDX_W-1:0];
  assign mis_idx  = mis_tag[IDX_W-1:0];
  assign cmp_live = cmp_valid && valid_vec[cmp_idx] && (gen_vec[cmp_idx] == cmp_tag[IDX_W]);
  assign mis_live = mis_valid && valid_vec[mis_idx] && (gen_vec[mis_idx] == mis_tag[IDX_W]);
  assign fault_hit = cmp_live && cmp_fault && mem_vec[cmp_idx];

  // rollback selection: the older of mispredict and fault wins
  assign rb_sel_fault = fault_hit && (!mis_live || ((cmp_idx - head_q) <= (mis_idx - head_q)));
  assign do_rb  = mis_live || fault_hit;
  assign rb_idx = rb_sel_fault ? cmp_idx : mis_idx;
  assign rb_age = rb_idx - head_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_squash
    assign squash_vec[i] = valid_vec[i] && ((IDX_W'(i) - head_q) > rb_age);
  end

  // dispatch
  assign need_ckpt  = ((cls == CLS_BR) && disp_lowconf) ||
                      ((cls == CLS_MEM) && (limp_mode || !mem_open_q));
  assign disp_ready = !do_rb && !(need_ckpt && full);
  assign disp_fire  = disp_valid && disp_ready;
  assign alloc      = disp_fire && need_ckpt;
  assign issue_idx  = need_ckpt ? tail_q : youngest;
  assign disp_tag   = need_ckpt ? {~gen_vec[tail_q], tail_q} : {gen_vec[youngest], youngest};

  // retirement
  assign retire_valid = (count_q > (IDX_W+1)'(1)) && bal_vec[head_q] && !do_rb;
  assign retire_fire  = retire_valid && retire_ready;
  assign retire_tag   = {gen_vec[head_q], head_q};

  assign clean_cmp = cmp_live && !cmp_fault && mem_vec[cmp_idx] && !do_rb;
  assign map_flat  = cur_map;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q     <= '0;
      tail_q     <= IDX_W'(1);
      count_q    <= (IDX_W+1)'(1);
      mem_open_q <= 1'b0;
    end else if (do_rb) begin
      tail_q     <= rb_idx + 1'b1;
      count_q    <= {1'b0, rb_age} + 1'b1;
      mem_open_q <= 1'b0;
    end else begin
      if (alloc) tail_q <= tail_q + 1'b1;
      if (retire_fire) head_q <= head_q + 1'b1;
      count_q <= count_q + {{IDX_W{1'b0}}, alloc} - {{IDX_W{1'b0}}, retire_fire};
      if (disp_fire) mem_open_q <= (cls == CLS_MEM) && !limp_mode;
    end
  end

  scq_rename_map #(.NUM_ARCH(NUM_ARCH), .PHYS_W(PHYS_W)) u_map (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (disp_fire && disp_dst_en),
    .wr_arch    (disp_dst_arch),
    .wr_phys    (disp_dst_phys),
    .restore_en (do_rb),
    .restore_map(rb_snap),
    .cur_map    (cur_map)
  );

  scq_slot_array #(.DEPTH(DEPTH), .NUM_ARCH(NUM_ARCH), .PHYS_W(PHYS_W), .CNT_W(CNT_W)) u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (alloc),
    .alloc_idx (tail_q),
    .alloc_mem (cls == CLS_MEM),
    .alloc_snap(cur_map),
    .issue_en  (disp_fire),
    .issue_idx (issue_idx),
    .cmp_en    (cmp_live && !fault_hit),
    .cmp_idx   (cmp_idx),
    .rb_en     (do_rb),
    .rb_idx    (rb_idx),
    .squash_vec(squash_vec),
    .retire_en (retire_fire),
    .retire_idx(head_q),
    .valid_vec (valid_vec),
    .gen_vec   (gen_vec),
    .mem_vec   (mem_vec),
    .bal_vec   (bal_vec),
    .rb_snap   (rb_snap)
  );

  scq_limp_ctrl #(.LIMP_QUIET(LIMP_QUIET), .TAG_W(TAG_W)) u_limp (
    .clk       (clk),
    .rst_n     (rst_n),
    .enter     (rb_sel_fault && !limp_mode),
    .report    (rb_sel_fault && limp_mode),
    .report_tag(cmp_tag),
    .clean_cmp (clean_cmp),
    .limp      (limp_mode),
    .rep_valid (fault_report_valid),
    .rep_tag   (fault_report_tag)
  );

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q <= (IDX_W+1)'(DEPTH)) && (count_q != '0));
  assert_retire_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    retire_fire |=> (head_q == $past(head_q) + 1'b1));
  assert_retire_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_valid && !retire_ready) |=> $stable(retire_tag));
  assert_restored_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    do_rb |=> bal_vec[$past(rb_idx)]);
  assert_fault_enters_limp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_sel_fault && !limp_mode) |=> limp_mode);
endmodule

// File: tb/test_spec_ckpt_queue.sv
module test_spec_ckpt_queue;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       disp_valid, disp_ready, disp_lowconf, disp_dst_en;
  logic [1:0] disp_class, disp_dst_arch;
  logic [3:0] disp_dst_phys;
  logic [2:0] disp_tag, cmp_tag, mis_tag, retire_tag, fault_report_tag;
  logic       cmp_valid, cmp_fault, mis_valid, retire_valid, retire_ready;
  logic       limp_mode, fault_report_valid;
  logic [15:0] map_flat;

  spec_ckpt_queue i_spec_ckpt_queue (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_class(disp_class),
    .disp_lowconf(disp_lowconf), .disp_dst_en(disp_dst_en), .disp_dst_arch(disp_dst_arch),
    .disp_dst_phys(disp_dst_phys), .disp_tag(disp_tag),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_fault(cmp_fault),
    .mis_valid(mis_valid), .mis_tag(mis_tag),
    .retire_valid(retire_valid), .retire_ready(retire_ready), .retire_tag(retire_tag),
    .limp_mode(limp_mode), .fault_report_valid(fault_report_valid),
    .fault_report_tag(fault_report_tag), .map_flat(map_flat)
  );

  int n_chk = 0;
  int n_bad = 0;

  // {class, lowconf, dst_en, arch, phys, exp_ready, exp_tag}
  localparam int NV = 10;
  localparam logic [13:0] VEC [NV] = '{
    {2'd0, 1'b0, 1'b1, 2'd1, 4'd5, 1'b1, 3'd0},  // R1 ALU joins slot 0
    {2'd1, 1'b0, 1'b0, 2'd0, 4'd0, 1'b1, 3'd0},  // R1 high-conf branch joins
    {2'd1, 1'b1, 1'b0, 2'd0, 4'd0, 1'b1, 3'd5},  // R1 low-conf opens slot 1
    {2'd2, 1'b0, 1'b1, 2'd2, 4'd6, 1'b1, 3'd6},  // R3 memory run opens slot 2
    {2'd2, 1'b0, 1'b1, 2'd3, 4'd7, 1'b1, 3'd6},  // R3 joins run
    {2'd0, 1'b0, 1'b1, 2'd0, 4'd8, 1'b1, 3'd6},  // R3 ALU ends run
    {2'd2, 1'b0, 1'b0, 2'd0, 4'd0, 1'b1, 3'd7},  // R3 new run opens slot 3
    {2'd1, 1'b1, 1'b0, 2'd0, 4'd0, 1'b0, 3'd0},  // R8 full, branch stalls
    {2'd2, 1'b0, 1'b0, 2'd0, 4'd0, 1'b1, 3'd7},  // R8 joining op still taken
    {2'd0, 1'b0, 1'b0, 2'd0, 4'd0, 1'b1, 3'd7}   // R1 ALU joins slot 3
  };

  function automatic logic [15:0] mk_map(int r0, int r1, int r2, int r3);
    return {4'(r3), 4'(r2), 4'(r1), 4'(r0)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    disp_valid = 0; disp_class = 0; disp_lowconf = 0; disp_dst_en = 0;
    disp_dst_arch = 0; disp_dst_phys = 0;
    cmp_valid = 0; cmp_tag = 0; cmp_fault = 0;
    mis_valid = 0; mis_tag = 0; retire_ready = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic disp(input int c, input bit lc, input bit de, input int a, input int p);
    disp_valid = 1; disp_class = 2'(c); disp_lowconf = lc;
    disp_dst_en = de; disp_dst_arch = 2'(a); disp_dst_phys = 4'(p);
  endtask

  task automatic cmp(input int t, input bit f);
    cmp_valid = 1; cmp_tag = 3'(t); cmp_fault = f;
  endtask

  task automatic retire_one(input string req, input int t);
    #1;
    chk({req, " retire_valid"}, 32'(retire_valid), 32'd1);
    chk({req, " retire_tag"}, 32'(retire_tag), 32'(t));
    retire_ready = 1;
    tick();
  endtask

  task automatic disp_chk(input string req, input int c, input bit lc, input int t);
    disp(c, lc, 1'b0, 0, 0);
    #1;
    chk({req, " ready"}, 32'(disp_ready), 32'd1);
    chk({req, " tag"}, 32'(disp_tag), 32'(t));
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R10 reset state
    disp_class = 2'd0;
    #1;
    chk("R10 ready", 32'(disp_ready), 32'd1);
    chk("R10 tag", 32'(disp_tag), 32'd0);
    chk("R10 retire_valid", 32'(retire_valid), 32'd0);
    chk("R10 limp", 32'(limp_mode), 32'd0);
    chk("R10 report", 32'(fault_report_valid), 32'd0);
    chk("R10 map", 32'(map_flat), 32'(mk_map(0, 1, 2, 3)));

    // vector table
    for (int v = 0; v < NV; v++) begin
      disp(int'(VEC[v][13:12]), VEC[v][11], VEC[v][10], int'(VEC[v][9:8]), int'(VEC[v][7:4]));
      #1;
      chk("R1 R3 R8 table ready", 32'(disp_ready), 32'(VEC[v][3]));
      if (VEC[v][3]) chk("R1 R3 table tag", 32'(disp_tag), 32'(VEC[v][2:0]));
      tick();
    end
    chk("R3 map after table", 32'(map_flat), 32'(mk_map(8, 5, 6, 7)));

    // R7 in-order retire
    cmp(5, 0); tick();
    #1 chk("R7 head incomplete", 32'(retire_valid), 32'd0);
    cmp(0, 0); tick();
    cmp(0, 0); tick();
    retire_one("R7 slot0", 0);
    retire_one("R7 slot1", 5);

    // R2 mispredict on slot 2
    mis_valid = 1; mis_tag = 3'd6;
    disp(0, 0, 0, 0, 0);
    #1 chk("R2 ready low in rollback", 32'(disp_ready), 32'd0);
    tick();
    chk("R2 map restored", 32'(map_flat), 32'(mk_map(0, 5, 2, 3)));
    disp_class = 2'd0;
    #1 chk("R2 restored is youngest", 32'(disp_tag), 32'd6);
    disp_chk("R1 reopen slot3", 1, 1'b1, 3);
    cmp(7, 0); tick();                         // R9 stale generation
    disp_chk("R1 reopen slot0", 1, 1'b1, 4);
    retire_one("R2 empty region retires", 6);
    #1 chk("R9 stale completion ignored", 32'(retire_valid), 32'd0);
    cmp(3, 0); tick();
    retire_one("R9 slot3", 3);

    // R4 group fault
    disp(2, 0, 1, 2, 9);
    #1 chk("R3 group opens", 32'(disp_tag), 32'd1);
    tick();
    disp(2, 0, 1, 3, 10);
    #1 chk("R3 group joins", 32'(disp_tag), 32'd1);
    tick();
    chk("R3 map", 32'(map_flat), 32'(mk_map(0, 5, 9, 10)));
    cmp(1, 1); tick();
    chk("R4 limp entered", 32'(limp_mode), 32'd1);
    chk("R4 map restored", 32'(map_flat), 32'(mk_map(0, 5, 2, 3)));
    chk("R4 no report", 32'(fault_report_valid), 32'd0);

    // R5 limp: one checkpoint per memory op, precise report
    disp_chk("R5 limp op A", 2, 1'b0, 2);
    disp_chk("R5 limp op B", 2, 1'b0, 7);
    disp(2, 0, 0, 0, 0);
    #1 chk("R8 full memory stall", 32'(disp_ready), 32'd0);
    tick();
    cmp(7, 1); tick();
    chk("R5 report valid", 32'(fault_report_valid), 32'd1);
    chk("R5 report tag", 32'(fault_report_tag), 32'd7);
    chk("R5 limp cleared", 32'(limp_mode), 32'd0);
    tick();
    chk("R5 report pulse", 32'(fault_report_valid), 32'd0);

    // R6 quiet exit
    cmp(4, 0); tick();
    retire_one("R7 slot0 again", 4);
    retire_one("R7 slot1 again", 1);
    disp_chk("R3 new run", 2, 1'b0, 0);
    disp_chk("R3 run joins", 2, 1'b0, 0);
    cmp(0, 1); tick();
    chk("R4 limp re-entered", 32'(limp_mode), 32'd1);
    disp_chk("R5 limp op C", 2, 1'b0, 5);
    cmp(5, 0); tick();
    chk("R6 still limp", 32'(limp_mode), 32'd1);
    cmp(2, 0); tick();
    chk("R6 quiet exit", 32'(limp_mode), 32'd0);
    retire_one("R7 slot2", 2);
    disp_chk("R6 grouping resumes open", 2, 1'b0, 6);
    disp_chk("R6 grouping resumes join", 2, 1'b0, 6);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule